// File: doc/BRIEF.md
# Byte-to-Packed-Word Address Translator

This block maps a byte address onto a flat memory built from 18-bit words in which bytes are packed back to back with no padding bits. Some bytes fall entirely inside one word. Others straddle the boundary between two neighbouring words. A memory controller in front of such an array hands the block a byte address and receives a description of where the bits of that byte live.

For each valid byte address, the block reports a first fragment (word address, bit position inside the word, number of bits). When the byte spills over, it also reports a second fragment in the next word. The second fragment always starts at bit 0 of that word.

The word index is the bit offset (byte address times 8) divided by 18. The bit offset is halved first. The division by 9 is then done as a multiply by a fixed reciprocal constant, followed by a right shift. The multiplier operands fit an 18x18 multiplier. The path is split over two register stages: the first holds the quotient and the second holds the remainder and the fragment split. Each stage carries a valid bit.

Top module: `byte_word_xlat`

## Requirements
- R1: `out_word_addr` equals floor(8*A/18) for the byte address A that was presented.
- R2: `out_start_bit` equals (8*A) mod 18. It is always even and lies in 0..16.
- R3: `out_len_first` equals min(8, 18 - `out_start_bit`).
- R4: `out_second_valid` is 1 exactly when `out_start_bit` is greater than 10.
- R5: When `out_second_valid` is 1, `out_second_addr` is `out_word_addr` + 1 and `out_len_second` is 8 - `out_len_first`. When it is 0, both `out_second_addr` and `out_len_second` are 0.
- R6: A byte address accepted with `in_valid` = 1 at a rising clock edge appears on the outputs, with `out_valid` = 1, two rising edges later. A new address may be accepted on every edge.
- R7: While `rst` is sampled high, every valid bit in the pipeline is cleared. `out_valid` is 0 after any edge at which `rst` was high.
- R8: The layout repeats every 9 bytes. For address A+9, the word address is 4 greater than for A, and the start bit is the same.
- R9: A cycle with `in_valid` = 0 yields `out_valid` = 0 two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte address strobe |
| in_byte_addr | input | 17 | Byte address to translate |
| out_valid | output | 1 | Outputs hold a translated address |
| out_word_addr | output | 16 | Word holding the first bits of the byte |
| out_start_bit | output | 5 | Bit position of the byte inside the first word |
| out_len_first | output | 4 | Number of byte bits in the first word |
| out_second_valid | output | 1 | Byte continues into the next word |
| out_second_addr | output | 16 | Word holding the remaining bits, or 0 |
| out_len_second | output | 4 | Number of byte bits in the second word, or 0 |

## Verification
The quotient-bound assertion relies on the reciprocal constant being exact for every address the port width allows. The chosen shift guarantees this for the whole 17-bit range. The bench therefore drives every value from 0 to 131071 and does not confine itself to a subset. The latency and reset assertions assume the address is stable only when it is sampled. The stimulus changes inputs on falling edges, holds valid high for the full sweep, and inserts bubbles and a mid-stream reset in separate phases, so that each valid output can be traced to exactly one accepted address.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Returns the smallest shift s for which ceil(n*2^s/d) gives an exact
  // floor(a*n/d) for every a in [0, 2^aw - 1].
  function automatic int recip_shift(input int aw, input int n, input int d);
    longint amax;
    amax = (longint'(1) << aw) - 1;
    for (int s = 1; s < 48; s++) begin
      longint scaled;
      longint m;
      longint err;
      scaled = longint'(n) << s;
      m      = (scaled + d - 1) / d;
      err    = m * d - scaled;
      if (amax * err < (longint'(1) << s)) return s;
    end
    return 48;
  endfunction

  // Returns the reciprocal multiplier that matches a given shift.
  function automatic longint recip_magic(input int s, input int n, input int d);
    return ((longint'(n) << s) + d - 1) / d;
  endfunction

endpackage

// File: rtl/xlat_quot_stage.sv
module xlat_quot_stage #(
  parameter int     BYTE_AW = 17,
  parameter int     BYTE_W  = 8,
  parameter int     WORD_W  = 18,
  parameter int     WORD_AW = 16,
  parameter int     MAG_W   = 18,
  parameter longint MAGIC   = 233017,
  parameter int     SHIFT   = 19
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [BYTE_AW-1:0] in_addr,
  output logic               s1_valid,
  output logic [BYTE_AW-1:0] s1_addr,
  output logic [WORD_AW-1:0] s1_word
);
  localparam int PROD_W = BYTE_AW + MAG_W;

  // The halved bit offset is addr*BYTE_W/2. Dividing it by WORD_W/2 is
  // done as addr * MAGIC >> SHIFT. MAGIC already contains the BYTE_W/2
  // factor, so the multiplier operand is the raw byte address.
  logic [PROD_W-1:0]  prod;
  logic [WORD_AW-1:0] quot;

  always_comb begin
    prod = PROD_W'(in_addr) * PROD_W'(MAGIC);
    quot = WORD_AW'(prod >> SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
    s1_addr <= in_addr;
    s1_word <= quot;
  end

  // The reciprocal quotient must bracket the true bit offset.
  assert_quot_bounds_R1: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> (longint'(s1_word) * WORD_W <= longint'(s1_addr) * BYTE_W) &&
                 ((longint'(s1_word) + 1) * WORD_W > longint'(s1_addr) * BYTE_W));

endmodule

// File: rtl/xlat_split_stage.sv
module xlat_split_stage #(
  parameter int BYTE_AW = 17,
  parameter int BYTE_W  = 8,
  parameter int WORD_W  = 18,
  parameter int WORD_AW = 16,
  parameter int SB_W    = 5,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s1_valid,
  input  logic [BYTE_AW-1:0] s1_addr,
  input  logic [WORD_AW-1:0] s1_word,
  output logic               out_valid,
  output logic [WORD_AW-1:0] out_word_addr,
  output logic [SB_W-1:0]    out_start_bit,
  output logic [LEN_W-1:0]   out_len_first,
  output logic               out_second_valid,
  output logic [WORD_AW-1:0] out_second_addr,
  output logic [LEN_W-1:0]   out_len_second
);
  localparam int BIT_W     = BYTE_AW + $clog2(BYTE_W);
  localparam int FIT_LIMIT = WORD_W - BYTE_W;

  logic [BIT_W-1:0]   bit_off;
  logic [BIT_W-1:0]   word_base;
  logic [BIT_W-1:0]   rem_full;
  logic [SB_W-1:0]    rem;
  logic               straddle;
  logic [LEN_W-1:0]   len1;
  logic [LEN_W-1:0]   len2;
  logic [WORD_AW-1:0] next_word;

  always_comb begin
    bit_off   = BIT_W'(s1_addr) << $clog2(BYTE_W);
    word_base = BIT_W'(s1_word) * BIT_W'(WORD_W);
    rem_full  = bit_off - word_base;
    rem       = SB_W'(rem_full);
    straddle  = rem > SB_W'(FIT_LIMIT);
    len1      = straddle ? LEN_W'(SB_W'(WORD_W) - rem) : LEN_W'(BYTE_W);
    len2      = straddle ? LEN_W'(BYTE_W) - len1 : '0;
    next_word = straddle ? s1_word + 1'b1 : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= s1_valid;
    end
    out_word_addr    <= s1_word;
    out_start_bit    <= rem;
    out_len_first    <= len1;
    out_second_valid <= straddle;
    out_second_addr  <= next_word;
    out_len_second   <= len2;
  end

  assert_start_range_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_start_bit) < WORD_W) && !out_start_bit[0]);

  assert_first_fits_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_len_first) <= BYTE_W) &&
                  (int'(out_start_bit) + int'(out_len_first) <= WORD_W));

  assert_pair_sum_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_second_valid) |->
      (int'(out_len_first) + int'(out_len_second) == BYTE_W) &&
      (int'(out_second_addr) == int'(out_word_addr) + 1));

  assert_second_null_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_second_valid) |->
      (out_len_second == '0) && (out_second_addr == '0) &&
      (int'(out_len_first) == BYTE_W));

endmodule

// File: rtl/byte_word_xlat.sv
module byte_word_xlat #(
  parameter int BYTE_AW = 17,
  parameter int BYTE_W  = 8,
  parameter int WORD_W  = 18,
  parameter int WORD_AW = $clog2(((2 ** BYTE_AW) * BYTE_W) / WORD_W + 2),
  parameter int SB_W    = $clog2(WORD_W),
  parameter int LEN_W   = $clog2(BYTE_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [BYTE_AW-1:0] in_byte_addr,
  output logic               out_valid,
  output logic [WORD_AW-1:0] out_word_addr,
  output logic [SB_W-1:0]    out_start_bit,
  output logic [LEN_W-1:0]   out_len_first,
  output logic               out_second_valid,
  output logic [WORD_AW-1:0] out_second_addr,
  output logic [LEN_W-1:0]   out_len_second
);
  localparam int     HALF_N = BYTE_W / 2;
  localparam int     HALF_D = WORD_W / 2;
  localparam int     SHIFT  = xlat_pkg::recip_shift(BYTE_AW, HALF_N, HALF_D);
  localparam longint MAGIC  = xlat_pkg::recip_magic(SHIFT, HALF_N, HALF_D);
  localparam int     MAG_W  = $clog2(MAGIC + 1);

  logic               s1_valid;
  logic [BYTE_AW-1:0] s1_addr;
  logic [WORD_AW-1:0] s1_word;

  xlat_quot_stage #(
    .BYTE_AW(BYTE_AW), .BYTE_W(BYTE_W), .WORD_W(WORD_W), .WORD_AW(WORD_AW),
    .MAG_W(MAG_W), .MAGIC(MAGIC), .SHIFT(SHIFT)
  ) u_quot (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_byte_addr),
    .s1_valid(s1_valid), .s1_addr(s1_addr), .s1_word(s1_word)
  );

  xlat_split_stage #(
    .BYTE_AW(BYTE_AW), .BYTE_W(BYTE_W), .WORD_W(WORD_W), .WORD_AW(WORD_AW),
    .SB_W(SB_W), .LEN_W(LEN_W)
  ) u_split (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_addr(s1_addr),
    .s1_word(s1_word), .out_valid(out_valid), .out_word_addr(out_word_addr),
    .out_start_bit(out_start_bit), .out_len_first(out_len_first),
    .out_second_valid(out_second_valid), .out_second_addr(out_second_addr),
    .out_len_second(out_len_second)
  );

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

endmodule

// File: tb/tb_byte_word_xlat.sv
`timescale 1ns/1ps
module tb_byte_word_xlat;
  localparam int AW = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [16:0] in_byte_addr = '0;
  logic        out_valid;
  logic [15:0] out_word_addr;
  logic [4:0]  out_start_bit;
  logic [3:0]  out_len_first;
  logic        out_second_valid;
  logic [15:0] out_second_addr;
  logic [3:0]  out_len_second;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic h1v = 0, h2v = 0;
  int   h1a = 0, h2a = 0;
  int   ring_addr [9];
  int   ring_word [9];
  int   ring_start[9];

  always #2 clk = ~clk;

  byte_word_xlat dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte_addr(in_byte_addr),
    .out_valid(out_valid), .out_word_addr(out_word_addr),
    .out_start_bit(out_start_bit), .out_len_first(out_len_first),
    .out_second_valid(out_second_valid), .out_second_addr(out_second_addr),
    .out_len_second(out_len_second)
  );

  task automatic chk(input string req, input int act, input int exp, input int a);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s addr=%0d actual=%0d expected=%0d", req, a, act, exp);
    end
  endtask

  task automatic check_out(input logic v, input int a);
    int s, l1, str;
    chk("R6/R9 out_valid", int'(out_valid), int'(v), a);
    if (v) begin
      s   = (8 * a) % 18;
      l1  = (s > 10) ? 18 - s : 8;
      str = (s > 10) ? 1 : 0;
      chk("R1 word", int'(out_word_addr), (8 * a) / 18, a);
      chk("R2 start", int'(out_start_bit), s, a);
      chk("R3 len_first", int'(out_len_first), l1, a);
      chk("R4 second_valid", int'(out_second_valid), str, a);
      chk("R5 second_addr", int'(out_second_addr), str ? (8 * a) / 18 + 1 : 0, a);
      chk("R5 len_second", int'(out_len_second), str ? 8 - l1 : 0, a);
      if (ring_addr[a % 9] == a - 9) begin
        chk("R8 word period", int'(out_word_addr), ring_word[a % 9] + 4, a);
        chk("R8 start period", int'(out_start_bit), ring_start[a % 9], a);
      end
      ring_addr[a % 9]  = a;
      ring_word[a % 9]  = int'(out_word_addr);
      ring_start[a % 9] = int'(out_start_bit);
    end
  endtask

  task automatic step(input logic v, input int a);
    @(negedge clk);
    check_out(h2v, h2a);
    h2v = h1v; h2a = h1a;
    h1v = v;   h1a = a;
    in_valid = v;
    in_byte_addr = 17'(a);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    for (int i = 0; i < 9; i++) ring_addr[i] = -100;
    // Reset state (R7)
    repeat (3) @(negedge clk);
    chk("R7 reset out_valid", int'(out_valid), 0, 0);
    rst = 1'b0;

    // Bubbles interleaved with valid addresses (R9, R6)
    for (int k = 0; k < 300; k++) step((k % 5) != 3, k);
    step(1'b0, 0);
    step(1'b0, 0);

    // Full back-to-back sweep of every address (R1..R6, R8)
    for (int i = 0; i < 9; i++) ring_addr[i] = -100;
    for (int a = 0; a < (1 << AW); a++) step(1'b1, a);
    step(1'b0, 0);
    step(1'b0, 0);

    // Mid-stream reset (R7)
    step(1'b1, 1234);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R7 reset mid-stream out_valid", int'(out_valid), 0, 1234);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 reset held out_valid", int'(out_valid), 0, 1234);
    rst = 1'b0;
    h1v = 0; h2v = 0;
    step(1'b0, 0);
    step(1'b0, 0);
    step(1'b0, 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

endmodule